// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Priority

This block sits between a processor and a single memory bus in a system whose cache writes through. Every processor store goes into a short in-order queue and is finished at once, so the processor keeps running while stores drain to memory when the bus has nothing more urgent to do. Loads that the cache cannot serve (instruction or data fetches) are the only requests that hold the processor. They take the bus ahead of any queued store. Because cache lines are never dirty in this scheme, no write-back is ever produced on replacement.

A load may target a location that still has a store waiting in the queue. In that case the newest queued value is returned in the same cycle, straight from the queue, and the bus is not used. A bus transaction, once granted, always runs to its acknowledge. Priority affects only the choice of the next grant.

The processor side uses a request/ready handshake: a request completes in a cycle where `cpu_req` and `cpu_ready` are both high. Load data is valid on `cpu_rdata` in that cycle. The memory side holds `mem_req` and its command fields steady until a one-cycle `mem_ack`. Read data arrives on `mem_rdata` together with that acknowledge.

Top module: `wt_write_buffer`

## Requirements
- R1: After reset the bus is idle (`mem_req` low) and the queue is empty, so a store request sees `cpu_ready` high at once.
- R2: A store is accepted in the cycle it is presented whenever fewer than DEPTH (default 4) stores are queued.
- R3: With DEPTH stores queued, a store request sees `cpu_ready` low until an entry drains. The queue never holds more than DEPTH entries.
- R4: Queued stores reach the bus in acceptance order. Each one is a bus write (`mem_we` high) carrying that entry's address and data, and the entry leaves the queue on its acknowledge.
- R5: A load with no matching queued store issues a bus read of `cpu_addr`. `cpu_ready` rises in the acknowledge cycle, with `cpu_rdata` equal to `mem_rdata`.
- R6: When the bus is idle and an unmatched load is waiting, the next grant is that read, even if stores are queued.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R8: A load whose address matches one or more queued stores completes in the same cycle with the data of the most recently accepted match, and no bus read is issued.
- R9: Draining runs without the processor: with the bus idle, a store accepted at one clock edge has `mem_req` high after the following edge.
- R10: Once a store has drained, a load of that address goes to the bus and returns memory data, not the old queued value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Load data, valid with `cpu_ready` on a load |
| mem_req | output | 1 | Bus transaction in progress |
| mem_we | output | 1 | Bus transaction is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_ack | input | 1 | One-cycle completion of the bus transaction |
| mem_rdata | input | DW | Bus read data, valid with `mem_ack` |

## Verification
On every cycle the assertions check four things. The bus command stays stable until its acknowledge. An idle bus with an unmatched load waiting grants a read of that address next. Store acceptance follows queue occupancy exactly, and forwarded loads complete at once without a bus read. Each write acknowledge removes exactly one queue entry. The bench scenarios cover what needs end-to-end knowledge of data: the order and contents of the drained writes, the placement of a load between stores already queued, the choice of the youngest of several matching stores, the one-cycle delay before draining starts, and the return to memory data once a location has drained.

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  logic          busy, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  logic          fwd_hit;
  logic [DW-1:0] fwd_data;

  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count && q_addr[head + PW'(i)] == cpu_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = q_data[head + PW'(i)];
      end
    end
  end

  wire full    = (count == CW'(DEPTH));
  wire rd_miss = cpu_req && !cpu_we && !fwd_hit;
  wire rd_done = busy && !bus_we && mem_ack;
  wire push    = cpu_req && cpu_we && !full;
  wire pop     = busy && bus_we && mem_ack;

  assign cpu_ready = cpu_req && (cpu_we ? !full : (fwd_hit || rd_done));
  assign cpu_rdata = fwd_hit ? fwd_data : mem_rdata;

  assign mem_req   = busy;
  assign mem_we    = bus_we;
  assign mem_addr  = bus_addr;
  assign mem_wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[tail] <= cpu_addr;
      q_data[tail] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (!busy) begin
      if (rd_miss) begin
        busy     <= 1'b1;
        bus_we   <= 1'b0;
        bus_addr <= cpu_addr;
      end else if (count != '0) begin
        busy      <= 1'b1;
        bus_we    <= 1'b1;
        bus_addr  <= q_addr[head];
        bus_wdata <= q_data[head];
      end
    end else if (mem_ack) begin
      busy <= 1'b0;
    end
  end

  wire unused_rd_done = rd_done;
endmodule

// File: rtl/wt_write_buffer_chk.sv
module wt_write_buffer_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [CW-1:0] count,
  input logic          fwd_hit
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && mem_we == $past(mem_we) &&
      mem_addr == $past(mem_addr) && mem_wdata == $past(mem_wdata));

  p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && cpu_req && !cpu_we && !fwd_hit |=>
      mem_req && !mem_we && mem_addr == $past(cpu_addr));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && int'(count) < DEPTH |-> cpu_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && int'(count) == DEPTH |-> !cpu_ready);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_fwd_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && fwd_hit |-> cpu_ready);

  p_fwd_nobus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && fwd_hit |=> !(mem_req && !mem_we));

  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=>
      int'(count) == int'($past(count)) - 1 + int'($past(cpu_req && cpu_we && cpu_ready)));
endmodule

bind wt_write_buffer wt_write_buffer_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .count(count), .fwd_hit(fwd_hit)
);

// File: tb/sim_wt_write_buffer.sv
module sim_wt_write_buffer;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int total = 0, bad = 0, wcnt = 0, nlog = 0;
  logic done = 1'b0;
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  always #(CLK_P/2) clk = ~clk;

  wt_write_buffer #(.AW(AW), .DW(DW), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      if (nlog < 64) begin
        log_we[nlog]   <= mem_we;
        log_addr[nlog] <= mem_addr;
        log_data[nlog] <= mem_wdata;
      end
      nlog <= nlog + 1;
    end else if (mem_req) begin
      if (wcnt == LAT) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memval(mem_addr);
        wcnt      <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    stalls = 0;
    #1;
    while (!cpu_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    stalls = 0;
    #1;
    while (!cpu_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    d = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      #1 chk("R1 bus idle after reset", mem_req, 0);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h10;
    #1 chk("R1 empty queue takes store", cpu_ready, 1);
    cpu_req = 1'b0;
    settle();
    chk("R1 no bus activity", nlog, 0);
  endtask

  task automatic t_single_write();
    int st, n0;
    n0 = nlog;
    cpu_write(32'h100, 32'h11, st);
    chk("R2 store without stall", st, 0);
    @(negedge clk);
    #1 chk("R9 bus still idle", mem_req, 0);
    @(negedge clk);
    #1 chk("R9 drain started", mem_req, 1);
    chk("R4 bus write", mem_we, 1);
    chk("R4 bus addr", mem_addr, 32'h100);
    settle();
    chk("R4 one write drained", nlog - n0, 1);
    chk("R4 drained data", log_data[n0], 32'h11);
  endtask

  task automatic t_burst();
    int st, sum, n0;
    n0 = nlog; sum = 0;
    for (int i = 0; i < 6; i++) begin
      cpu_write(32'h200 + 4 * i, 32'hB0 + i, st);
      sum += st;
    end
    chk("R3 full queue stalled a store", sum > 0, 1);
    settle();
    chk("R4 six writes drained", nlog - n0, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R4 order addr", log_addr[n0 + i], 32'h200 + 4 * i);
      chk("R4 order data", log_data[n0 + i], 32'hB0 + i);
    end
  endtask

  task automatic t_read_miss();
    int st, n0;
    logic [DW-1:0] d;
    n0 = nlog;
    cpu_read(32'h300, d, st);
    chk("R5 read data", d, memval(32'h300));
    chk("R5 read stalled", st > 0, 1);
    settle();
    chk("R5 one bus read", nlog - n0, 1);
    chk("R5 bus read kind", log_we[n0], 0);
    chk("R5 bus read addr", log_addr[n0], 32'h300);
  endtask

  task automatic t_priority();
    int st, n0;
    logic [DW-1:0] d;
    n0 = nlog;
    cpu_write(32'h400, 32'hA1, st);
    cpu_write(32'h404, 32'hA2, st);
    cpu_write(32'h408, 32'hA3, st);
    cpu_read(32'h500, d, st);
    chk("R6 read data", d, memval(32'h500));
    settle();
    chk("R6 four transactions", nlog - n0, 4);
    chk("R7 in-flight write finished first", log_addr[n0], 32'h400);
    chk("R7 in-flight write data", log_data[n0], 32'hA1);
    chk("R6 read before queued writes", log_we[n0 + 1], 0);
    chk("R6 read addr", log_addr[n0 + 1], 32'h500);
    chk("R6 then B", log_addr[n0 + 2], 32'h404);
    chk("R6 then C", log_addr[n0 + 3], 32'h408);
  endtask

  task automatic t_forward();
    int st, n0, nr;
    logic [DW-1:0] d;
    n0 = nlog;
    cpu_write(32'h600, 32'h1, st);
    cpu_write(32'h600, 32'h2, st);
    cpu_write(32'h604, 32'h7, st);
    cpu_read(32'h600, d, st);
    chk("R8 youngest match", d, 32'h2);
    chk("R8 no stall", st, 0);
    cpu_read(32'h604, d, st);
    chk("R8 other entry", d, 32'h7);
    chk("R8 no stall 2", st, 0);
    settle();
    nr = 0;
    for (int i = n0; i < nlog; i++) if (!log_we[i]) nr++;
    chk("R8 no bus reads", nr, 0);
    chk("R8 writes still drain", nlog - n0, 3);
    cpu_read(32'h600, d, st);
    chk("R10 drained location from memory", d, memval(32'h600));
    chk("R10 read went to bus", st > 0, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single_write();
    t_burst();
    t_read_miss();
    t_priority();
    t_forward();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule